// File: doc/BRIEF.md
# LCD Display Mode Pixel Selector

This block decides, frame by frame, which segment pixels are lit for each common line of a segment LCD driver. Software writes pixel patterns into a user buffer through a simple write port. At each end-of-frame pulse the block copies the whole user buffer into a display buffer, so the pattern on the glass changes only at frame boundaries. The waveform generator downstream presents the index of the common it is driving and receives the 64-bit pixel vector for that common.

A control word selects one of eight display modes and a blink period counted in frames. The modes can force all pixels off or on, invert the pattern, blink the pattern or its inverse against a blank screen, hold the display buffer frozen while software rewrites the user buffer, or alternate between the user and display buffers. The modes only shape the output: the stored pixel words are never altered by them. A new control word is staged and becomes active at the next frame boundary.

Top module: `lcdpx_mode_sel`

## Requirements
- R1: After reset both buffers hold zero, the active and staged mode is 0 with blink field 0, the blink phase is visible, and `pix_out` is zero for every common.
- R2: A write to byte address 0x200 + 8·k stores the low pixel word (pix_out bits 31:0) of common k, and 0x200 + 8·k + 4 stores the high word (bits 63:32), for k in 0..5. In mode 0 the new data appears only in the cycle after the next `frame_end` pulse, when the user buffer is copied into the display buffer.
- R3: A write to address 0x040 stages the mode in bits 2:0 and the blink field in bits 11:4; the staged values become active on the next `frame_end` pulse, and until then the previous mode stays in effect.
- R4: Mode 1 drives all pixels off and mode 2 drives all pixels on; returning to mode 0 shows the unchanged stored pattern.
- R5: Mode 4 drives the bitwise inverse of the display buffer.
- R6: While the mode taking effect at a boundary is 6, that boundary performs no copy, so the display buffer is frozen and shown as-is; the first boundary that activates any other mode copies again.
- R7: With a nonzero blink field B the blink phase toggles after every B+1 frame boundaries; a zero field holds the phase visible; any boundary that changes the mode resets the phase to visible and restarts the count.
- R8: Mode 3 shows the display buffer in the visible phase and all pixels off in the blank phase.
- R9: Mode 5 shows the inverse of the display buffer in the visible phase and all pixels off in the blank phase.
- R10: Mode 7 shows the user buffer in the visible phase and the display buffer in the blank phase. Mode 0 and mode 6 show the display buffer.
- R11: A common index of 6 or more yields all pixels off, and writes to addresses outside the pixel area and the control word leave every buffer and the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 12 | Byte address of the write |
| wr_data | input | 32 | Write data |
| frame_end | input | 1 | One-cycle pulse marking a frame boundary |
| com_idx | input | 3 | Index of the common being driven |
| pix_out | output | 64 | Pixel on/off vector for `com_idx` |

## Verification
The assertions assume `frame_end` is a single-cycle pulse and that control writes and frame pulses never fall into the same cycle, so the staged word seen at a boundary is the one written earlier. The bench drives every input on the falling edge, separates each write from the following frame pulse by at least one cycle, and keeps the common index steady while it samples. Blink and copy behaviour are then checked against a frame-level model of the two buffers, the staged and active control words and the phase counter.

// File: rtl/lcdpx_pkg.sv
package lcdpx_pkg;

    typedef enum logic [2:0] {
        DM_NORMAL    = 3'd0,
        DM_ALL_OFF   = 3'd1,
        DM_ALL_ON    = 3'd2,
        DM_BLINK     = 3'd3,
        DM_INVERT    = 3'd4,
        DM_INV_BLINK = 3'd5,
        DM_HOLD      = 3'd6,
        DM_ALTERNATE = 3'd7
    } disp_mode_e;

    typedef enum logic {
        PH_SHOW  = 1'b0,
        PH_BLANK = 1'b1
    } blink_phase_e;

    localparam int BLINK_W   = 8;
    localparam int MODE_W    = 3;
    localparam int MODE_LSB  = 0;
    localparam int BLINK_LSB = 4;

    typedef struct packed {
        disp_mode_e           mode;
        logic [BLINK_W-1:0]   rate;
    } disp_ctrl_t;

    localparam disp_ctrl_t CTRL_RESET = '{mode: DM_NORMAL, rate: '0};

    function automatic logic mode_blocks_copy(disp_mode_e m);
        return m == DM_HOLD;
    endfunction

    function automatic blink_phase_e flip_phase(blink_phase_e p);
        return (p == PH_SHOW) ? PH_BLANK : PH_SHOW;
    endfunction

endpackage

// File: rtl/lcdpx_wr_decode.sv
module lcdpx_wr_decode #(
    parameter int          ADDR_W    = 12,
    parameter int          N_COM     = 6,
    parameter int          COM_W     = 3,
    parameter logic [11:0] MEM_BASE  = 12'h200,
    parameter logic [11:0] CTRL_ADDR = 12'h040
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              ctrl_we,
    output logic              mem_we,
    output logic [COM_W-1:0]  mem_com,
    output logic              mem_hi
);
    localparam int MEM_SPAN = 8 * N_COM;

    logic [ADDR_W-1:0] offset;
    logic              in_mem;

    always_comb begin
        offset  = wr_addr - ADDR_W'(MEM_BASE);
        in_mem  = (wr_addr >= ADDR_W'(MEM_BASE)) && (offset < ADDR_W'(MEM_SPAN));
        mem_we  = wr_en && in_mem;
        mem_com = COM_W'(offset >> 3);
        mem_hi  = offset[2];
        ctrl_we = wr_en && ((wr_addr >> 2) == (ADDR_W'(CTRL_ADDR) >> 2));
    end
endmodule

// File: rtl/lcdpx_pixel_bank.sv
module lcdpx_pixel_bank #(
    parameter int N_COM  = 6,
    parameter int WORD_W = 32,
    parameter int COM_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [COM_W-1:0]           wr_com,
    input  logic                       wr_hi,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic                       copy_en,
    input  logic [COM_W-1:0]           rd_com,
    output logic                       rd_valid,
    output logic [2*WORD_W-1:0]        user_rd,
    output logic [2*WORD_W-1:0]        disp_rd,
    output logic [N_COM*2*WORD_W-1:0]  user_flat,
    output logic [N_COM*2*WORD_W-1:0]  disp_flat
);
    localparam int PIX_W = 2 * WORD_W;

    for (genvar c = 0; c < N_COM; c++) begin : g_com
        logic [PIX_W-1:0] user_q;
        logic [PIX_W-1:0] disp_q;
        logic             hit;

        assign hit = wr_en && (wr_com == COM_W'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                user_q <= '0;
                disp_q <= '0;
            end else begin
                if (copy_en) begin
                    disp_q <= user_q;
                end
                if (hit && wr_hi) begin
                    user_q[PIX_W-1:WORD_W] <= wr_data;
                end
                if (hit && !wr_hi) begin
                    user_q[WORD_W-1:0] <= wr_data;
                end
            end
        end

        assign user_flat[c*PIX_W +: PIX_W] = user_q;
        assign disp_flat[c*PIX_W +: PIX_W] = disp_q;
    end

    always_comb begin
        rd_valid = {1'b0, rd_com} < (COM_W+1)'(N_COM);
        user_rd  = '0;
        disp_rd  = '0;
        for (int c = 0; c < N_COM; c++) begin
            if (rd_com == COM_W'(c)) begin
                user_rd = user_flat[c*PIX_W +: PIX_W];
                disp_rd = disp_flat[c*PIX_W +: PIX_W];
            end
        end
    end
endmodule

// File: rtl/lcdpx_frame_ctrl.sv
module lcdpx_frame_ctrl
    import lcdpx_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         ctrl_we,
    input  disp_ctrl_t   ctrl_in,
    input  logic         frame_end,
    output disp_ctrl_t   pend_ctrl,
    output disp_ctrl_t   act_ctrl,
    output blink_phase_e phase,
    output logic         copy_en
);
    disp_ctrl_t         pend_q;
    disp_ctrl_t         act_q;
    blink_phase_e       phase_q;
    logic [BLINK_W-1:0] frame_cnt_q;
    logic               restart;

    assign restart = (pend_q.mode != act_q.mode) || (pend_q.rate == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= CTRL_RESET;
            act_q       <= CTRL_RESET;
            phase_q     <= PH_SHOW;
            frame_cnt_q <= '0;
        end else begin
            if (ctrl_we) begin
                pend_q <= ctrl_in;
            end
            if (frame_end) begin
                act_q <= pend_q;
                if (restart) begin
                    phase_q     <= PH_SHOW;
                    frame_cnt_q <= '0;
                end else if (frame_cnt_q >= pend_q.rate) begin
                    phase_q     <= flip_phase(phase_q);
                    frame_cnt_q <= '0;
                end else begin
                    frame_cnt_q <= frame_cnt_q + 1'b1;
                end
            end
        end
    end

    assign copy_en   = frame_end && !mode_blocks_copy(pend_q.mode);
    assign pend_ctrl = pend_q;
    assign act_ctrl  = act_q;
    assign phase     = phase_q;
endmodule

// File: rtl/lcdpx_shaper.sv
module lcdpx_shaper
    import lcdpx_pkg::*;
#(
    parameter int PIX_W = 64
) (
    input  disp_mode_e         mode,
    input  blink_phase_e       phase,
    input  logic               valid,
    input  logic [PIX_W-1:0]   disp_px,
    input  logic [PIX_W-1:0]   user_px,
    output logic [PIX_W-1:0]   pix
);
    logic             show;
    logic [PIX_W-1:0] shaped;

    always_comb begin
        show = (phase == PH_SHOW);
        case (mode)
            DM_NORMAL,
            DM_HOLD:      shaped = disp_px;
            DM_ALL_OFF:   shaped = '0;
            DM_ALL_ON:    shaped = '1;
            DM_BLINK:     shaped = show ? disp_px : '0;
            DM_INVERT:    shaped = ~disp_px;
            DM_INV_BLINK: shaped = show ? ~disp_px : '0;
            DM_ALTERNATE: shaped = show ? user_px : disp_px;
            default:      shaped = '0;
        endcase
        pix = valid ? shaped : '0;
    end
endmodule

// File: rtl/lcdpx_mode_sel.sv
module lcdpx_mode_sel
    import lcdpx_pkg::*;
#(
    parameter int          N_COM     = 6,
    parameter int          WORD_W    = 32,
    parameter int          ADDR_W    = 12,
    parameter int          COM_W     = $clog2(N_COM),
    parameter logic [11:0] MEM_BASE  = 12'h200,
    parameter logic [11:0] CTRL_ADDR = 12'h040
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                frame_end,
    input  logic [COM_W-1:0]    com_idx,
    output logic [2*WORD_W-1:0] pix_out
);
    localparam int PIX_W  = 2 * WORD_W;
    localparam int FLAT_W = N_COM * PIX_W;

    logic               ctrl_we;
    logic               mem_we;
    logic [COM_W-1:0]   mem_com;
    logic               mem_hi;
    logic               copy_en;
    logic               rd_valid;
    logic [PIX_W-1:0]   user_rd;
    logic [PIX_W-1:0]   disp_rd;
    logic [FLAT_W-1:0]  user_flat;
    logic [FLAT_W-1:0]  disp_flat;
    disp_ctrl_t         ctrl_in;
    disp_ctrl_t         pend_ctrl;
    disp_ctrl_t         act_ctrl;
    blink_phase_e       phase;

    assign ctrl_in.mode = disp_mode_e'(wr_data[MODE_LSB +: MODE_W]);
    assign ctrl_in.rate = wr_data[BLINK_LSB +: BLINK_W];

    lcdpx_wr_decode #(
        .ADDR_W(ADDR_W), .N_COM(N_COM), .COM_W(COM_W),
        .MEM_BASE(MEM_BASE), .CTRL_ADDR(CTRL_ADDR)
    ) u_decode (
        .wr_en(wr_en), .wr_addr(wr_addr),
        .ctrl_we(ctrl_we), .mem_we(mem_we), .mem_com(mem_com), .mem_hi(mem_hi)
    );

    lcdpx_pixel_bank #(
        .N_COM(N_COM), .WORD_W(WORD_W), .COM_W(COM_W)
    ) u_bank (
        .clk(clk), .rst(rst),
        .wr_en(mem_we), .wr_com(mem_com), .wr_hi(mem_hi), .wr_data(wr_data),
        .copy_en(copy_en), .rd_com(com_idx), .rd_valid(rd_valid),
        .user_rd(user_rd), .disp_rd(disp_rd),
        .user_flat(user_flat), .disp_flat(disp_flat)
    );

    lcdpx_frame_ctrl u_frame (
        .clk(clk), .rst(rst),
        .ctrl_we(ctrl_we), .ctrl_in(ctrl_in), .frame_end(frame_end),
        .pend_ctrl(pend_ctrl), .act_ctrl(act_ctrl), .phase(phase),
        .copy_en(copy_en)
    );

    lcdpx_shaper #(.PIX_W(PIX_W)) u_shape (
        .mode(act_ctrl.mode), .phase(phase), .valid(rd_valid),
        .disp_px(disp_rd), .user_px(user_rd), .pix(pix_out)
    );
endmodule

// File: rtl/lcdpx_mode_sel_chk.sv
module lcdpx_mode_sel_chk
    import lcdpx_pkg::*;
#(
    parameter int N_COM  = 6,
    parameter int WORD_W = 32,
    parameter int COM_W  = 3
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        frame_end,
    input logic [COM_W-1:0]            com_idx,
    input logic [2*WORD_W-1:0]         pix_out,
    input disp_ctrl_t                  pend_ctrl,
    input disp_ctrl_t                  act_ctrl,
    input blink_phase_e                phase,
    input logic [N_COM*2*WORD_W-1:0]   user_flat,
    input logic [N_COM*2*WORD_W-1:0]   disp_flat
);
    logic com_ok;
    assign com_ok = {1'b0, com_idx} < (COM_W+1)'(N_COM);

    // R3: active control only moves at a frame boundary
    p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(act_ctrl));

    p_take_effect_r3: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> act_ctrl == $past(pend_ctrl));

    // R2: boundary copy of the whole user buffer
    p_copy_r2: assert property (@(posedge clk) disable iff (rst)
        frame_end && pend_ctrl.mode != DM_HOLD |=> disp_flat == $past(user_flat));

    // R6: display buffer frozen between boundaries and at holding boundaries
    p_disp_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !frame_end || pend_ctrl.mode == DM_HOLD |=> $stable(disp_flat));

    // R7: phase behaviour
    p_phase_reset_r7: assert property (@(posedge clk) disable iff (rst)
        frame_end && (pend_ctrl.mode != act_ctrl.mode || pend_ctrl.rate == '0)
        |=> phase == PH_SHOW);

    p_phase_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(phase));

    // R4: forced modes
    p_all_off_r4: assert property (@(posedge clk) disable iff (rst)
        act_ctrl.mode == DM_ALL_OFF |-> pix_out == '0);

    p_all_on_r4: assert property (@(posedge clk) disable iff (rst)
        act_ctrl.mode == DM_ALL_ON && com_ok |-> pix_out == '1);

    // R8 / R9: blank phase of the blinking modes
    p_blank_r8: assert property (@(posedge clk) disable iff (rst)
        (act_ctrl.mode == DM_BLINK || act_ctrl.mode == DM_INV_BLINK) && phase == PH_BLANK
        |-> pix_out == '0);

    // R11: out-of-range common
    p_range_r11: assert property (@(posedge clk) disable iff (rst)
        !com_ok |-> pix_out == '0);
endmodule

bind lcdpx_mode_sel lcdpx_mode_sel_chk #(
    .N_COM(N_COM), .WORD_W(WORD_W), .COM_W(COM_W)
) u_chk (
    .clk(clk), .rst(rst), .frame_end(frame_end), .com_idx(com_idx),
    .pix_out(pix_out), .pend_ctrl(pend_ctrl), .act_ctrl(act_ctrl),
    .phase(phase), .user_flat(user_flat), .disp_flat(disp_flat)
);

// File: tb/test_lcdpx_mode_sel.sv
module test_lcdpx_mode_sel;
    localparam int NC   = 6;
    localparam int NROW = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        frame_end = 1'b0;
    logic [2:0]  com_idx = '0;
    logic [63:0] pix_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference state kept at frame granularity
    logic [63:0] m_user [NC];
    logic [63:0] m_disp [NC];
    int m_pmode, m_prate, m_mode, m_cnt;
    bit m_blank;

    // rows: mode[18:16], blink field[15:8], frames[7:0]
    localparam logic [18:0] ROWS [NROW] = '{
        {3'd0, 8'd0, 8'd2}, {3'd1, 8'd0, 8'd1}, {3'd2, 8'd0, 8'd1},
        {3'd4, 8'd0, 8'd1}, {3'd3, 8'd1, 8'd6}, {3'd5, 8'd2, 8'd7},
        {3'd3, 8'd0, 8'd3}, {3'd7, 8'd1, 8'd5}, {3'd0, 8'd0, 8'd1}
    };

    always #4 clk = ~clk;

    lcdpx_mode_sel i_lcdpx_mode_sel (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_end(frame_end), .com_idx(com_idx),
        .pix_out(pix_out)
    );

    function automatic logic [63:0] exp_pix(int c);
        if (c >= NC) return '0;
        case (m_mode)
            1: return '0;
            2: return '1;
            3: return m_blank ? 64'd0 : m_disp[c];
            4: return ~m_disp[c];
            5: return m_blank ? 64'd0 : ~m_disp[c];
            7: return m_blank ? m_disp[c] : m_user[c];
            default: return m_disp[c];
        endcase
    endfunction

    function automatic string mode_tag(int m);
        case (m)
            1, 2: return "R4";
            3: return "R8";
            4: return "R5";
            5: return "R9";
            6: return "R6";
            7: return "R10";
            default: return "R2";
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NC; c++) begin
            m_user[c] = '0;
            m_disp[c] = '0;
        end
        m_pmode = 0; m_prate = 0; m_mode = 0; m_cnt = 0; m_blank = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        int off;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        off = int'(a) - 'h200;
        if ((a >> 2) == ('h040 >> 2)) begin
            m_pmode = int'(d[2:0]);
            m_prate = int'(d[11:4]);
        end else if (a >= 12'h200 && off < 8 * NC) begin
            if (off[2]) m_user[off >> 3][63:32] = d;
            else        m_user[off >> 3][31:0]  = d;
        end
    endtask

    task automatic set_mode(input int m, input int rate);
        wr(12'h040, 32'((rate << 4) | m));
    endtask

    task automatic frame();
        @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        if (m_pmode != 6)
            for (int c = 0; c < NC; c++) m_disp[c] = m_user[c];
        if (m_pmode != m_mode || m_prate == 0) begin
            m_blank = 1'b0; m_cnt = 0;
        end else if (m_cnt >= m_prate) begin
            m_blank = ~m_blank; m_cnt = 0;
        end else begin
            m_cnt++;
        end
        m_mode = m_pmode;
    endtask

    task automatic check(input int c, input string tag);
        logic [63:0] e;
        com_idx = 3'(c);
        #1;
        e = exp_pix(c);
        n_chk++;
        if (pix_out !== e) begin
            n_fail++;
            $display("FAIL %s com=%0d actual=%h expected=%h", tag, c, pix_out, e);
        end
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < NC; c++) check(c, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check_all("R1");

        // R2: word placement and deferred visibility
        for (int c = 0; c < NC; c++) begin
            wr(12'(32'h200 + 8 * c),     32'hA5C3_0000 ^ 32'(c * 32'h1111));
            wr(12'(32'h204 + 8 * c),     32'h0F0F_0000 + 32'(c));
        end
        @(negedge clk);
        check(0, "R2");
        if (pix_out !== 64'd0) $display("FAIL R2 visible before boundary actual=%h expected=0", pix_out);
        frame();
        check_all("R2");
        com_idx = 3'd2; #1;
        n_chk++;
        if (pix_out[31:0] !== (32'hA5C3_0000 ^ 32'h2222) || pix_out[63:32] !== 32'h0F0F_0002) begin
            n_fail++;
            $display("FAIL R2 word position actual=%h expected=%h", pix_out,
                     {32'h0F0F_0002, 32'hA5C3_0000 ^ 32'h2222});
        end

        // R3: staged control takes effect only at the boundary
        set_mode(1, 0);
        check(1, "R3");
        frame();
        check(1, "R3");

        // table of mode/blink/frame-count rows
        for (int r = 0; r < NROW; r++) begin
            set_mode(int'(ROWS[r][18:16]), int'(ROWS[r][15:8]));
            for (int f = 0; f < int'(ROWS[r][7:0]); f++) begin
                frame();
                check_all(mode_tag(m_mode));
            end
        end

        // R6: holding mode freezes the display buffer
        set_mode(6, 0);
        frame();
        wr(12'h210, 32'hDEAD_BEEF);
        frame();
        frame();
        check(2, "R6");
        set_mode(0, 0);
        frame();
        check(2, "R6");

        // R10: alternate mode shows the live user buffer when visible
        set_mode(7, 3);
        frame();
        wr(12'h218, 32'h1234_5678);
        check(3, "R10");
        frame();
        check(3, "R10");

        // R7: zero field holds visible; mode change restarts phase
        set_mode(3, 0);
        for (int f = 0; f < 4; f++) begin
            frame();
            check(0, "R7");
        end
        set_mode(3, 1);
        frame(); frame(); frame();
        check(0, "R7");
        set_mode(5, 1);
        frame();
        check(0, "R7");
        frame(); frame();
        check(0, "R7");

        // R11: out-of-range common and ignored writes
        set_mode(0, 0);
        frame();
        check(6, "R11");
        check(7, "R11");
        wr(12'h230, 32'hFFFF_FFFF);
        wr(12'h1FC, 32'hFFFF_FFFF);
        wr(12'h044, 32'h0000_0002);
        frame();
        check_all("R11");

        // R1: reset again mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_all("R1");
        frame();
        check_all("R1");

        finish_run();
    end
endmodule